// File: doc/BRIEF.md
# Sequential Add-and-Shift Unsigned Multiplier

This block multiplies two unsigned operands over several clock cycles using the classic add-and-shift method. A single-cycle start pulse captures the multiplicand into its own register and places the multiplier in the low half of a combined shift register. That register is one bit wider than the product. Each step examines the bit at the bottom of the register. When that bit is one, the multiplicand is added into the upper half, and the adder's carry lands in the extra top bit. The whole register then shifts right by one. The adder is a sectioned carry-select adder. After one step per multiplier bit, a done flag rises and the product is held until the next start.

A user pulses `start` with both operands valid and then waits for `done`. The run time depends on the operands: every multiplier bit costs a test cycle and a shift cycle, and every one bit costs an extra add cycle. A start pulse that arrives while a product is being formed is ignored.

Top module: `shmul_top`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `product` is 0 and `done` is 0.
- R2: A `start` pulse seen at a clock edge while the block is idle captures `op_a` and `op_b` at that edge. `done` is 0 after that edge.
- R3: Once `done` is 1, `product` equals `op_a * op_b` as unsigned numbers for every operand pair. This includes 0xFF*0xFF = 0xFE01 and products with a zero operand.
- R4: `done` becomes 1 exactly 2 + 2*W + popcount(`op_b`) clock edges after the start edge is counted as the first, where W = 8 by default.
- R5: While `done` is 1 and `start` is low, `done` stays 1 and `product` does not change.
- R6: A `start` pulse while a product is being formed is ignored. It does not change the result or the completion time of the run in progress.
- R7: In an add step, the carry out of the upper-half sum is kept in the top bit of the shift register and moves into the product on the next shift. No product bit is lost.
- R8: Changes on `op_a` and `op_b` after the start edge have no effect on the run in progress.
- R9: A `start` pulse while `done` is 1 begins a new product immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a product |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| product | output | 16 | Result, valid while `done` is 1 |
| done | output | 1 | High once the product is complete, low from the next accepted start |

## Verification
The hardest case to reach from the ports is a start pulse that lands inside a run, and at the same moment the operands change underneath it. In the bench, some random runs pulse `start` a few cycles into the run and replace `op_a`/`op_b` right after the start edge. The product and the exact completion cycle are then compared with values from the first pair only. Carry retention into the top bit only shows on sums that overflow the upper half, so all-ones operands are also driven directly and with random high-weight values.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_INIT  = 3'd1,
      ST_TEST  = 3'd2,
      ST_ADD   = 3'd3,
      ST_SHIFT = 3'd4
   } shmul_state_e;

endpackage

// File: rtl/shmul_csa_adder.sv
// Sectioned carry-select adder: the first section ripples from cin,
// every later section computes both carry cases and selects.
module shmul_csa_adder #(
   parameter int W   = 8,
   parameter int SEC = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   localparam int NSEC = W / SEC;

   generate
      if (W < 1 || SEC < 1 || (W % SEC) != 0) begin : g_bad_params
         $error("shmul_csa_adder: W must be a positive multiple of SEC");
      end
   endgenerate

   logic [NSEC:0] carry;
   assign carry[0] = cin;

   genvar gi;
   generate
      for (gi = 0; gi < NSEC; gi++) begin : g_sec
         logic [SEC-1:0] a_s, b_s;
         assign a_s = a[gi*SEC +: SEC];
         assign b_s = b[gi*SEC +: SEC];
         if (gi == 0) begin : g_ripple
            logic [SEC:0] s;
            assign s = {1'b0, a_s} + {1'b0, b_s} + {{SEC{1'b0}}, carry[0]};
            assign sum[gi*SEC +: SEC] = s[SEC-1:0];
            assign carry[gi+1]        = s[SEC];
         end else begin : g_select
            logic [SEC:0] s0, s1;
            assign s0 = {1'b0, a_s} + {1'b0, b_s};
            assign s1 = {1'b0, a_s} + {1'b0, b_s} + {{SEC{1'b0}}, 1'b1};
            assign sum[gi*SEC +: SEC] = carry[gi] ? s1[SEC-1:0] : s0[SEC-1:0];
            assign carry[gi+1]        = carry[gi] ? s1[SEC] : s0[SEC];
         end
      end
   endgenerate

   assign cout = carry[NSEC];

endmodule

// File: rtl/shmul_datapath.sv
module shmul_datapath #(
   parameter int W   = 8,
   parameter int SEC = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_en,
   input  logic           add_en,
   input  logic           shift_en,
   input  logic [W-1:0]   op_a,
   input  logic [W-1:0]   op_b,
   output logic           lsb,
   output logic [2*W-1:0] product
);
   localparam int RW = 2 * W + 1;

   logic [W-1:0]  mcand;
   logic [RW-1:0] acc;
   logic [W-1:0]  upper_sum;
   logic          upper_cout;

   shmul_csa_adder #(.W(W), .SEC(SEC)) u_adder (
      .a    (acc[2*W-1:W]),
      .b    (mcand),
      .cin  (1'b0),
      .sum  (upper_sum),
      .cout (upper_cout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand <= '0;
         acc   <= '0;
      end else if (load_en) begin
         mcand <= op_a;
         acc   <= {{(W+1){1'b0}}, op_b};
      end else if (add_en) begin
         acc[RW-1:W] <= {upper_cout, upper_sum};
      end else if (shift_en) begin
         acc <= {1'b0, acc[RW-1:1]};
      end
   end

   assign lsb     = acc[0];
   assign product = acc[2*W-1:0];

   p_load_clears_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (acc[RW-1:W] == '0));

   p_add_keeps_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      add_en |=> (acc[RW-1:W] == ({1'b0, $past(acc[2*W-1:W])} + {1'b0, $past(mcand)})));

   p_shift_empties_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (acc[RW-1] == 1'b0));

endmodule

// File: rtl/shmul_ctrl.sv
module shmul_ctrl
   import shmul_pkg::*;
#(
   parameter int W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic lsb,
   output logic load_en,
   output logic add_en,
   output logic shift_en,
   output logic done
);
   localparam int STEP_W = (W > 1) ? $clog2(W) : 1;
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(W - 1);

   shmul_state_e      state;
   logic [STEP_W-1:0] step;

   assign load_en  = (state == ST_IDLE) && start;
   assign add_en   = (state == ST_ADD);
   assign shift_en = (state == ST_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         step  <= '0;
         done  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_INIT;
                  done  <= 1'b0;
               end
            end
            ST_INIT: begin
               step  <= '0;
               state <= ST_TEST;
            end
            ST_TEST: state <= lsb ? ST_ADD : ST_SHIFT;
            ST_ADD:  state <= ST_SHIFT;
            ST_SHIFT: begin
               step <= step + 1'b1;
               if (step == LAST_STEP) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  state <= ST_TEST;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_done_only_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (state == ST_IDLE));

   p_start_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (!done && state == ST_INIT));

   p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_SHIFT && start) |=> (state != ST_INIT && state != ST_IDLE));

   p_one_command_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_en, add_en, shift_en}));

endmodule

// File: rtl/shmul_top.sv
module shmul_top #(
   parameter int W   = 8,
   parameter int SEC = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [W-1:0]   op_a,
   input  logic [W-1:0]   op_b,
   output logic [2*W-1:0] product,
   output logic           done
);
   generate
      if (W < 2) begin : g_bad_width
         $error("shmul_top: W must be at least 2");
      end
   endgenerate

   logic load_en, add_en, shift_en, lsb;

   shmul_ctrl #(.W(W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .lsb      (lsb),
      .load_en  (load_en),
      .add_en   (add_en),
      .shift_en (shift_en),
      .done     (done)
   );

   shmul_datapath #(.W(W), .SEC(SEC)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .add_en   (add_en),
      .shift_en (shift_en),
      .op_a     (op_a),
      .op_b     (op_b),
      .lsb      (lsb),
      .product  (product)
   );

   p_hold_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(product)));

   p_restart_from_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> !done);

endmodule

// File: tb/tb_shmul_top.sv
module tb_shmul_top;
   localparam int W       = 8;
   localparam int CLK_PER = 10;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   op_a = '0;
   logic [W-1:0]   op_b = '0;
   logic [2*W-1:0] product;
   logic           done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   shmul_top #(.W(W)) dut (
      .clk (clk), .rst_n (rst_n), .start (start),
      .op_a (op_a), .op_b (op_b), .product (product), .done (done)
   );

   always #(CLK_PER/2) clk = ~clk;

   function automatic logic [2*W-1:0] exp_prod(input logic [W-1:0] a, input logic [W-1:0] b);
      return {{W{1'b0}}, a} * {{W{1'b0}}, b};
   endfunction

   function automatic int exp_lat(input logic [W-1:0] b);
      int ones = 0;
      for (int i = 0; i < W; i++) ones += int'(b[i]);
      return 2 + 2 * W + ones;
   endfunction

   task automatic check(input string req, input bit ok, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   // One product; poke = extra start mid-run (R6), churn = operands change after capture (R8)
   task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke, input bit churn);
      int n;
      @(negedge clk);
      op_a  = a;
      op_b  = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      check("R2 done low after start", done == 1'b0, done, 0);
      if (churn) begin
         op_a = W'($urandom);
         op_b = W'($urandom);
      end
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
         start = (poke && n == 5);
      end
      start = 1'b0;
      check(poke ? "R6 latency with busy start" : "R4 latency", n == exp_lat(b), n, exp_lat(b));
      check(churn ? "R8 product with churned operands" :
            (poke ? "R6 product with busy start" : "R3 product"),
            product == exp_prod(a, b), product, exp_prod(a, b));
   endtask

   initial begin
      int seed_init;
      logic [2*W-1:0] held;
      seed_init = int'($urandom(32'h00C0FFEE));
      #(CLK_PER * 2);
      @(negedge clk);
      check("R1 product in reset", product == '0, product, 0);
      check("R1 done in reset", done == 1'b0, done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done after reset", done == 1'b0, done, 0);

      // directed corners
      run(8'hFF, 8'hFF, 0, 0);           // R3 R7 carry into top bit
      run(8'h00, 8'hA5, 0, 0);           // R3 zero multiplicand
      run(8'h9C, 8'h00, 0, 0);           // R3 R4 no add steps
      run(8'hFF, 8'h80, 0, 0);           // R7 last-step add
      run(8'h01, 8'h01, 0, 0);

      // R5 hold
      held = product;
      repeat (6) @(negedge clk);
      check("R5 done held", done == 1'b1, done, 1);
      check("R5 product held", product == held, product, held);

      run(8'h3B, 8'hD7, 1, 0);           // R6
      run(8'hE1, 8'h6E, 0, 1);           // R8
      run(8'hFF, 8'hFF, 1, 1);           // R6 R8 R7 together

      // R9 restart while done: runs are issued with done already high
      check("R9 done high before restart", done == 1'b1, done, 1);
      run(8'h12, 8'h34, 0, 0);

      for (int k = 0; k < 60; k++) begin
         run(W'($urandom), W'($urandom | ((k % 3 == 0) ? 32'hF0 : 32'h0)),
             (k % 4) == 1, (k % 5) == 2);
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule